// File: doc/BRIEF.md
# Indexed-Element Vector Multiply-Accumulate Unit

This unit decodes one 32-bit SIMD instruction word for the multiply-add-by-element operation and runs it on a 128-bit vector datapath. From the word it takes the vector length bit, the element size, the lane index bits, and the three register numbers. It also checks the fixed opcode bits and reports encodings that are reserved.

The register numbers for the first and second sources come out combinationally, so a register file outside the unit can return the operands in the same cycle. The unit takes one scalar lane from the second source and multiplies every lane of the first source by it. It keeps the low element-width bits of each product and adds them, with wrap-around, to the matching lane of the destination operand. The outcome is registered, so it appears exactly one cycle after the instruction. The outcome is one of three: a write-back (data plus destination register), an undefined-encoding flag, or a not-this-instruction flag.

Top module: `vmla_idx_unit`

## Requirements
- R1: The word matches only when bit 31 = 0, bits 29:24 = 101111, bits 15:12 = 0000 and bit 10 = 0. A valid word that does not match raises `out_nomatch` one cycle later, with `out_valid` and `out_undef` low.
- R2: A matching word with size field (bits 23:22) equal to 00 or 11 raises `out_undef` one cycle later. It causes no write-back: `out_valid` stays low and `out_data` keeps its value.
- R3: With size 01, lanes are 16 bits wide. The lane index is {H,L,M} = {bit 11, bit 21, bit 20}, and the second-source register number `rs_m` is {0, bits 19:16}, so it never exceeds 15.
- R4: With size 10, lanes are 32 bits wide. The lane index is {H,L} = {bit 11, bit 21}, and `rs_m` is {bit 20, bits 19:16}.
- R5: `rs_n` equals bits 9:5 of the word combinationally. On a write-back, `out_rd` equals bits 4:0 of the word.
- R6: Each result lane is the unsigned sum of the destination lane and the low lane-width bits of (first-source lane × scalar), taken modulo 2^lane-width.
- R7: The scalar is the indexed lane of the full 128-bit second-source vector: lane k occupies bits k·w+w−1 : k·w. The same scalar is used in every lane.
- R8: Q is bit 30. When Q = 0, only the low 64 bits are computed and bits 127:64 of `out_data` are zero. When Q = 1, all 128 bits are computed.
- R9: Every cycle with `in_valid` high gives exactly one of `out_valid`, `out_undef` or `out_nomatch` on the next cycle, whatever the data. A cycle with `in_valid` low gives none of them.
- R10: A synchronous active-high reset clears `out_valid`, `out_undef`, `out_nomatch`, `out_rd` and `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands present |
| in_instr | input | 32 | Instruction word |
| in_vn | input | 128 | First-source vector |
| in_vm | input | 128 | Second-source (indexed) vector |
| in_vd | input | 128 | Destination vector before accumulation |
| rs_n | output | 5 | First-source register number (combinational) |
| rs_m | output | 5 | Second-source register number (combinational) |
| out_valid | output | 1 | Write-back strobe |
| out_undef | output | 1 | Reserved-encoding flag |
| out_nomatch | output | 1 | Word is not this instruction |
| out_rd | output | 5 | Destination register number of the write-back |
| out_data | output | 128 | Accumulated result vector |

## Verification
The bench builds the unit with its default 128-bit vector width, which is the width the encoding defines. At this width, both lane sizes, both vector lengths, and every index value from 0 to 7 can be reached, including the top 16-bit lane at bits 127:112. A behavioural reference model, using loops over integers, predicts the registered outcome of every cycle. Directed words cover index and register-bank corners, all-ones wrap cases, reserved sizes, and opcode mismatches. A few hundred random words and operands follow, with idle gaps between them.

// File: rtl/vmla_pkg.sv
package vmla_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;

  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef struct packed {
    logic              match;
    logic              undef;
    logic              q;
    logic [1:0]        sz;
    logic [2:0]        idx;
    logic [REG_AW-1:0] rm;
    logic [REG_AW-1:0] rn;
    logic [REG_AW-1:0] rd;
  } vmla_dec_t;
endpackage

// File: rtl/vmla_decode.sv
module vmla_decode
  import vmla_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output vmla_dec_t          dec
);
  logic       bit_h, bit_l, bit_m;
  logic [3:0] rm_lo;
  logic [1:0] sz;

  assign bit_h = instr[11];
  assign bit_l = instr[21];
  assign bit_m = instr[20];
  assign rm_lo = instr[19:16];
  assign sz    = instr[23:22];

  always_comb begin
    dec.match = (instr[31] == 1'b0) && (instr[29:24] == 6'b101111) &&
                (instr[15:12] == 4'b0000) && (instr[10] == 1'b0);
    dec.undef = (sz != SZ_HALF) && (sz != SZ_WORD);
    dec.q     = instr[30];
    dec.sz    = sz;
    dec.rn    = instr[9:5];
    dec.rd    = instr[4:0];
    if (sz == SZ_HALF) begin
      dec.idx = {bit_h, bit_l, bit_m};
      dec.rm  = {1'b0, rm_lo};
    end else begin
      dec.idx = {1'b0, bit_h, bit_l};
      dec.rm  = {bit_m, rm_lo};
    end
  end
endmodule

// File: rtl/vmla_lanes.sv
module vmla_lanes
  import vmla_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [1:0]       sz,
  input  logic             q,
  input  logic [2:0]       idx,
  input  logic [VEC_W-1:0] vn,
  input  logic [VEC_W-1:0] vm,
  input  logic [VEC_W-1:0] vd,
  output logic [VEC_W-1:0] res
);
  localparam int HW   = 16;
  localparam int WW   = 32;
  localparam int L16  = VEC_W / HW;
  localparam int L32  = VEC_W / WW;
  localparam int HALF = VEC_W / 2;

  logic [HW-1:0]    s16;
  logic [WW-1:0]    s32;
  logic [VEC_W-1:0] r16, r32, full;

  // scalar lane taken from the whole second-source vector
  always_comb begin
    s16 = '0;
    s32 = '0;
    for (int k = 0; k < L16; k++)
      if (int'(idx) == k) s16 = vm[k*HW +: HW];
    for (int k = 0; k < L32; k++)
      if (int'(idx[1:0]) == k) s32 = vm[k*WW +: WW];
  end

  genvar g;
  generate
    for (g = 0; g < L16; g++) begin : g_h
      logic [HW-1:0] prod;
      assign prod = vn[g*HW +: HW] * s16;
      assign r16[g*HW +: HW] = vd[g*HW +: HW] + prod;
    end
    for (g = 0; g < L32; g++) begin : g_w
      logic [WW-1:0] prod;
      assign prod = vn[g*WW +: WW] * s32;
      assign r32[g*WW +: WW] = vd[g*WW +: WW] + prod;
    end
  endgenerate

  assign full = (sz == SZ_WORD) ? r32 : r16;
  assign res  = q ? full : {{(VEC_W-HALF){1'b0}}, full[HALF-1:0]};
endmodule

// File: rtl/vmla_idx_unit.sv
module vmla_idx_unit
  import vmla_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   in_instr,
  input  logic [VEC_W-1:0]     in_vn,
  input  logic [VEC_W-1:0]     in_vm,
  input  logic [VEC_W-1:0]     in_vd,
  output logic [REG_AW-1:0]    rs_n,
  output logic [REG_AW-1:0]    rs_m,
  output logic                 out_valid,
  output logic                 out_undef,
  output logic                 out_nomatch,
  output logic [REG_AW-1:0]    out_rd,
  output logic [VEC_W-1:0]     out_data
);
  localparam int HALF = VEC_W / 2;

  vmla_dec_t        dec;
  logic [VEC_W-1:0] lane_res;
  logic             wb_go;
  logic             q_r;

  vmla_decode u_dec (.instr(in_instr), .dec(dec));

  vmla_lanes #(.VEC_W(VEC_W)) u_lanes (
    .sz(dec.sz), .q(dec.q), .idx(dec.idx),
    .vn(in_vn), .vm(in_vm), .vd(in_vd), .res(lane_res)
  );

  assign rs_n  = dec.rn;
  assign rs_m  = dec.rm;
  assign wb_go = in_valid && dec.match && !dec.undef;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_undef   <= 1'b0;
      out_nomatch <= 1'b0;
      out_rd      <= '0;
      out_data    <= '0;
      q_r         <= 1'b0;
    end else begin
      out_valid   <= wb_go;
      out_undef   <= in_valid && dec.match && dec.undef;
      out_nomatch <= in_valid && !dec.match;
      if (wb_go) begin
        out_rd   <= dec.rd;
        out_data <= lane_res;
        q_r      <= dec.q;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, out_undef, out_nomatch})); // R9
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid || out_undef || out_nomatch)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(out_valid || out_undef || out_nomatch)); // R9
  AST_UNDEF_NO_WB: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> $stable(out_data)); // R2
  AST_HALF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !q_r) |-> (out_data[VEC_W-1:HALF] == '0)); // R8
  AST_RM_LOW_BANK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_instr[23:22] == SZ_HALF) |-> !rs_m[REG_AW-1]); // R3
endmodule

// File: tb/sim_vmla_idx_unit.sv
module sim_vmla_idx_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  in_instr = '0;
  logic [127:0] in_vn = '0, in_vm = '0, in_vd = '0;
  logic [4:0]   rs_n, rs_m, out_rd;
  logic         out_valid, out_undef, out_nomatch;
  logic [127:0] out_data;

  int n_cmp = 0, n_bad = 0;

  // expected registered outcome
  logic         e_valid = 0, e_undef = 0, e_nomatch = 0;
  logic [4:0]   e_rd = '0;
  logic [127:0] e_data = '0;

  always #5 clk = ~clk;

  vmla_idx_unit u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_vn(in_vn), .in_vm(in_vm), .in_vd(in_vd), .rs_n(rs_n), .rs_m(rs_m),
    .out_valid(out_valid), .out_undef(out_undef), .out_nomatch(out_nomatch),
    .out_rd(out_rd), .out_data(out_data));

  function automatic logic [31:0] mk(bit q, bit [1:0] sz, bit l, bit m, bit h,
                                     bit [3:0] rm, bit [4:0] rn, bit [4:0] rd);
    return {1'b0, q, 6'b101111, sz, l, m, rm, 4'b0000, h, 1'b0, rn, rd};
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk(out_valid === e_valid, "R9 out_valid", 128'(out_valid), 128'(e_valid));
    chk(out_undef === e_undef, "R2 out_undef", 128'(out_undef), 128'(e_undef));
    chk(out_nomatch === e_nomatch, "R1 out_nomatch", 128'(out_nomatch), 128'(e_nomatch));
    chk(out_rd === e_rd, "R5 out_rd", 128'(out_rd), 128'(e_rd));
    chk(out_data === e_data, "R6 R7 R8 out_data", out_data, e_data);
  endtask

  // behavioural model of one issue; also checks the combinational numbers
  task automatic issue(bit v, logic [31:0] w, logic [127:0] n, logic [127:0] m, logic [127:0] d);
    bit match;
    int es, lanes, idx;
    logic [4:0] mreg;
    longint unsigned mask, sc, a, b, p;
    logic [127:0] r;
    @(negedge clk);
    compare_outputs();
    in_valid = v; in_instr = w; in_vn = n; in_vm = m; in_vd = d;
    #1;
    match = (w[31] == 0) && (w[29:24] == 6'b101111) && (w[15:12] == 0) && (w[10] == 0);
    chk(rs_n === w[9:5], "R5 rs_n", 128'(rs_n), 128'(w[9:5]));
    if (w[23:22] == 2'b01) begin
      idx = int'(w[11]) * 4 + int'(w[21]) * 2 + int'(w[20]);
      mreg = {1'b0, w[19:16]};
      chk(rs_m === mreg, "R3 rs_m", 128'(rs_m), 128'(mreg));
      es = 16;
    end else begin
      idx = int'(w[11]) * 2 + int'(w[21]);
      mreg = {w[20], w[19:16]};
      if (w[23:22] == 2'b10) chk(rs_m === mreg, "R4 rs_m", 128'(rs_m), 128'(mreg));
      es = 32;
    end
    e_valid   = 0; e_undef = 0; e_nomatch = 0;
    if (!v) return;
    if (!match) begin e_nomatch = 1; return; end
    if (w[23:22] == 2'b00 || w[23:22] == 2'b11) begin e_undef = 1; return; end
    e_valid = 1;
    e_rd = w[4:0];
    mask = (64'd1 << es) - 1;
    lanes = (w[30] ? 128 : 64) / es;
    sc = 64'(m >> (idx * es)) & mask;
    r = '0;
    for (int e = 0; e < lanes; e++) begin
      a = 64'(n >> (e * es)) & mask;
      b = 64'(d >> (e * es)) & mask;
      p = (b + ((a * sc) & mask)) & mask;
      r = r | (128'(p) << (e * es));
    end
    e_data = r;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] ramp;
    for (int k = 0; k < 8; k++) ramp[k*16 +: 16] = 16'(16'h1000 + k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    compare_outputs();
    rst = 1'b0;
    // R3 R7: 16-bit index 7 picks bits 127:112, register 15
    issue(1, mk(1, 2'b01, 1, 1, 1, 4'hF, 5'd3, 5'd9), {8{16'd2}}, ramp, {8{16'd5}});
    // R3 R8: Q=0, index 0
    issue(1, mk(0, 2'b01, 0, 0, 0, 4'h2, 5'd1, 5'd2), rnd128(), ramp, rnd128());
    // R4 R7: 32-bit index 3 with M selecting the high bank
    issue(1, mk(1, 2'b10, 1, 1, 1, 4'h4, 5'd7, 5'd31), rnd128(), rnd128(), rnd128());
    // R4 R8: 32-bit Q=0
    issue(1, mk(0, 2'b10, 0, 1, 1, 4'h0, 5'd0, 5'd0), rnd128(), rnd128(), rnd128());
    // R6: all-ones wrap, both sizes
    issue(1, mk(1, 2'b01, 0, 1, 0, 4'h1, 5'd1, 5'd1), '1, '1, '1);
    issue(1, mk(1, 2'b10, 1, 0, 0, 4'h1, 5'd1, 5'd1), '1, '1, '1);
    // R2: reserved sizes
    issue(1, mk(1, 2'b00, 1, 1, 1, 4'h3, 5'd2, 5'd4), rnd128(), rnd128(), rnd128());
    issue(1, mk(1, 2'b11, 0, 0, 0, 4'h3, 5'd2, 5'd4), rnd128(), rnd128(), rnd128());
    // R1: each fixed field broken in turn
    issue(1, mk(1, 2'b01, 0, 0, 0, 4'h3, 5'd2, 5'd4) | 32'h8000_0000, rnd128(), rnd128(), rnd128());
    issue(1, mk(1, 2'b01, 0, 0, 0, 4'h3, 5'd2, 5'd4) ^ 32'h0100_0000, rnd128(), rnd128(), rnd128());
    issue(1, mk(1, 2'b10, 0, 0, 0, 4'h3, 5'd2, 5'd4) | 32'h0000_4000, rnd128(), rnd128(), rnd128());
    issue(1, mk(1, 2'b10, 0, 0, 0, 4'h3, 5'd2, 5'd4) | 32'h0000_0400, rnd128(), rnd128(), rnd128());
    // R9: idle gap
    issue(0, mk(1, 2'b01, 0, 0, 0, 4'h3, 5'd2, 5'd4), rnd128(), rnd128(), rnd128());
    issue(0, '0, '0, '0, '0);
    // random mix
    for (int t = 0; t < 400; t++) begin
      logic [31:0] w;
      w = mk($urandom % 2 == 1, 2'($urandom), $urandom % 2 == 1, $urandom % 2 == 1,
             $urandom % 2 == 1, 4'($urandom), 5'($urandom), 5'($urandom));
      if ($urandom % 16 == 0) w = w ^ (32'd1 << ($urandom % 32));
      issue($urandom % 5 != 0, w, rnd128(), rnd128(), rnd128());
    end
    issue(0, '0, '0, '0, '0);
    @(negedge clk);
    compare_outputs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule